// File: doc/BRIEF.md
# Common-Bus Register Transfer Datapath

This block is a small register-transfer datapath. Four general registers of equal width and two memory-side registers all hang off one shared word bus. The memory-side registers are an address register and a data register. A three-bit source code chooses, through a multiplexer, what drives the bus. The choices are one of the four general registers, the data register, the zero-extended address register, an external constant, or an all-zero word.

A three-bit destination code goes through a decoder. The decoder raises the load enable of at most one register, and only while the transfer condition is 1. The selected register takes the bus word on the next rising clock edge.

A small internal word memory is reached only through the address and data registers. With its chip select asserted, a read copies the addressed word into the data register and a write stores the data register into the addressed word. The address register takes the low address bits of whatever is on the bus. This lets the address field of the data register be moved into it with an ordinary transfer. A controller steps the datapath by presenting one set of codes per clock.

Top module: `rt_bus_datapath`

## Requirements
- R1: A synchronous active-high reset clears the four general registers, the address register and the data register to zero.
- R2: Source code 000, 001, 010 and 011 put registers A, B, C and D on the bus. 100 puts the data register on the bus. 101 puts the address register on the bus, zero-extended. 110 puts the constant input on the bus. 111 puts an all-zero word on the bus.
- R3: While the transfer condition is 1, destination code 000, 001, 010 and 011 loads A, B, C and D. Code 100 loads the address register with the low 4 bits of the bus, and 101 loads the data register. Codes 110 and 111 load nothing, and every register other than the one decoded keeps its value.
- R4: While the transfer condition is 0, no register changes, whatever the source and destination codes are.
- R5: A load takes effect only at the rising clock edge. Before that edge the destination still shows its old value.
- R6: With chip select and read both 1, the data register is loaded at the edge with the memory word addressed by the address register.
- R7: With chip select and write both 1 and read 0, the data register is stored at the edge into the memory word addressed by the address register.
- R8: With chip select 0, read and write have no effect on the data register or on the memory.
- R9: When read and write are both 1 with chip select, the write is ignored and the read proceeds.
- R10: A memory read and a bus load into the data register in the same cycle leave the memory word in the data register.
- R11: A memory access uses the address and data register values from before the edge, even when the same cycle loads either register from the bus.
- R12: Moving the data register onto the bus with the address register as destination puts its low 4 bits into the address register.
- R13: Any register can be loaded with the constant input in one transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all loads on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| xfer_en | input | 1 | Transfer condition; gates the destination decoder |
| src_sel | input | 3 | Bus source code |
| dst_sel | input | 3 | Destination code |
| const_word | input | 16 | Constant word offered to the bus |
| mem_cs | input | 1 | Memory chip select |
| mem_rd | input | 1 | Memory read request |
| mem_wr | input | 1 | Memory write request |
| reg_a_q | output | 16 | Register A |
| reg_b_q | output | 16 | Register B |
| reg_c_q | output | 16 | Register C |
| reg_d_q | output | 16 | Register D |
| ar_q | output | 4 | Address register |
| dr_q | output | 16 | Data register |

## Verification
A memory access and a bus transfer can land on the same clock edge. The bench steps the datapath with a reference model that applies old register values to the memory and lets a read override a bus load of the data register. It provokes the clash by driving a read together with a transfer into the data register, and a write together with a transfer into the address register. The outcome is then judged both from the registers right after the edge and from a later read of the touched words. A read with a write in the same cycle is judged the same way, by reading back the word that must remain unchanged.

// File: rtl/rtb_pkg.sv
package rtb_pkg;

  localparam int NUM_GP  = 4;
  localparam int NUM_DST = 6;

  typedef enum logic [2:0] {
    SRC_A     = 3'd0,
    SRC_B     = 3'd1,
    SRC_C     = 3'd2,
    SRC_D     = 3'd3,
    SRC_DR    = 3'd4,
    SRC_AR    = 3'd5,
    SRC_CONST = 3'd6,
    SRC_ZERO  = 3'd7
  } src_e;

  typedef enum logic [2:0] {
    DST_A    = 3'd0,
    DST_B    = 3'd1,
    DST_C    = 3'd2,
    DST_D    = 3'd3,
    DST_AR   = 3'd4,
    DST_DR   = 3'd5,
    DST_NIL6 = 3'd6,
    DST_NIL7 = 3'd7
  } dst_e;

endpackage

// File: rtl/rtb_bus_mux.sv
module rtb_bus_mux
  import rtb_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 4
) (
  input  logic [NUM_GP-1:0][W-1:0] gp,
  input  logic [W-1:0]             dr,
  input  logic [AW-1:0]            ar,
  input  logic [W-1:0]             konst,
  input  src_e                     sel,
  output logic [W-1:0]             bus
);

  always_comb begin
    unique case (sel)
      SRC_A:     bus = gp[0];
      SRC_B:     bus = gp[1];
      SRC_C:     bus = gp[2];
      SRC_D:     bus = gp[3];
      SRC_DR:    bus = dr;
      SRC_AR:    bus = {{(W-AW){1'b0}}, ar};
      SRC_CONST: bus = konst;
      default:   bus = '0;
    endcase
  end

endmodule

// File: rtl/rtb_dest_decoder.sv
module rtb_dest_decoder
  import rtb_pkg::*;
(
  input  logic               en,
  input  dst_e               dst,
  output logic [NUM_DST-1:0] ld
);

  for (genvar i = 0; i < NUM_DST; i++) begin : g_dec
    assign ld[i] = en && (3'(dst) == 3'(i));
  end

endmodule

// File: rtl/rtb_word_mem.sv
module rtb_word_mem #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          cs,
  input  logic          rd,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic          rd_fire,
  output logic          wr_fire
);

  logic [W-1:0] store [DEPTH];

  assign rd_fire = cs & rd;
  assign wr_fire = cs & wr & ~rd;

  always_ff @(posedge clk) begin
    if (wr_fire) store[addr] <= wdata;
  end

  assign rdata = store[addr];

endmodule

// File: rtl/rt_bus_datapath.sv
module rt_bus_datapath
  import rtb_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int MEM_DEPTH = 16,
  localparam int ADDR_W   = $clog2(MEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer_en,
  input  logic [2:0]        src_sel,
  input  logic [2:0]        dst_sel,
  input  logic [DATA_W-1:0] const_word,
  input  logic              mem_cs,
  input  logic              mem_rd,
  input  logic              mem_wr,
  output logic [DATA_W-1:0] reg_a_q,
  output logic [DATA_W-1:0] reg_b_q,
  output logic [DATA_W-1:0] reg_c_q,
  output logic [DATA_W-1:0] reg_d_q,
  output logic [ADDR_W-1:0] ar_q,
  output logic [DATA_W-1:0] dr_q
);

  localparam int LD_AR = 4;
  localparam int LD_DR = 5;

  logic [NUM_GP-1:0][DATA_W-1:0] gp_q;
  logic [DATA_W-1:0]             bus_w;
  logic [NUM_DST-1:0]            ld_en;
  logic [DATA_W-1:0]             mem_rdata;
  logic                          mem_rfire;
  logic                          mem_wfire;

  rtb_bus_mux #(.W(DATA_W), .AW(ADDR_W)) u_mux (
    .gp    (gp_q),
    .dr    (dr_q),
    .ar    (ar_q),
    .konst (const_word),
    .sel   (src_e'(src_sel)),
    .bus   (bus_w)
  );

  rtb_dest_decoder u_dec (
    .en  (xfer_en),
    .dst (dst_e'(dst_sel)),
    .ld  (ld_en)
  );

  rtb_word_mem #(.W(DATA_W), .DEPTH(MEM_DEPTH), .AW(ADDR_W)) u_mem (
    .clk     (clk),
    .cs      (mem_cs),
    .rd      (mem_rd),
    .wr      (mem_wr),
    .addr    (ar_q),
    .wdata   (dr_q),
    .rdata   (mem_rdata),
    .rd_fire (mem_rfire),
    .wr_fire (mem_wfire)
  );

  for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
    always_ff @(posedge clk) begin
      if (rst)            gp_q[g] <= '0;
      else if (ld_en[g])  gp_q[g] <= bus_w;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               ar_q <= '0;
    else if (ld_en[LD_AR]) ar_q <= bus_w[ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)               dr_q <= '0;
    else if (mem_rfire)    dr_q <= mem_rdata;
    else if (ld_en[LD_DR]) dr_q <= bus_w;
  end

  assign reg_a_q = gp_q[0];
  assign reg_b_q = gp_q[1];
  assign reg_c_q = gp_q[2];
  assign reg_d_q = gp_q[3];

endmodule

// File: rtl/rtb_checker.sv
module rtb_checker
  import rtb_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     xfer_en,
  input logic [2:0]               src_sel,
  input logic [2:0]               dst_sel,
  input logic                     mem_cs,
  input logic                     mem_rd,
  input logic                     mem_wr,
  input logic [NUM_GP-1:0][W-1:0] gp,
  input logic [AW-1:0]            ar,
  input logic [W-1:0]             dr,
  input logic [W-1:0]             bus,
  input logic [NUM_DST-1:0]       ld,
  input logic [W-1:0]             mem_rdata,
  input logic                     mem_wfire
);

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1: the edge after a reset edge sees every register at zero
  always_ff @(posedge clk) begin
    if (rst_d) begin
      a_r1_reset_clears : assert (gp == '0 && ar == '0 && dr == '0)
        else $error("a_r1_reset_clears");
    end
  end

  a_r2_bus_gp : assert property (@(posedge clk) disable iff (rst)
    (src_sel[2] == 1'b0) |-> (bus == gp[src_sel[1:0]]));

  a_r3_onehot : assert property (@(posedge clk) disable iff (rst)
    $onehot0(ld));

  for (genvar g = 0; g < NUM_GP; g++) begin : g_ld
    a_r3_gp_load : assert property (@(posedge clk) disable iff (rst)
      (xfer_en && dst_sel == 3'(g)) |=> (gp[g] == $past(bus)));
  end

  a_r4_hold : assert property (@(posedge clk) disable iff (rst)
    !xfer_en |=> ($stable(gp) && $stable(ar)));

  a_r6_read : assert property (@(posedge clk) disable iff (rst)
    (mem_cs && mem_rd) |=> (dr == $past(mem_rdata)));

  a_r8_no_cs : assert property (@(posedge clk) disable iff (rst)
    !mem_cs |-> !mem_wfire);

  a_r9_rd_wins : assert property (@(posedge clk) disable iff (rst)
    (mem_rd && mem_wr) |-> !mem_wfire);

endmodule

bind rt_bus_datapath rtb_checker #(.W(DATA_W), .AW(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .xfer_en   (xfer_en),
  .src_sel   (src_sel),
  .dst_sel   (dst_sel),
  .mem_cs    (mem_cs),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .gp        (gp_q),
  .ar        (ar_q),
  .dr        (dr_q),
  .bus       (bus_w),
  .ld        (ld_en),
  .mem_rdata (mem_rdata),
  .mem_wfire (mem_wfire)
);

// File: tb/rt_bus_datapath_tb.sv
module rt_bus_datapath_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        xfer_en = 1'b0;
  logic [2:0]  src_sel = '0;
  logic [2:0]  dst_sel = '0;
  logic [15:0] const_word = '0;
  logic        mem_cs = 1'b0, mem_rd = 1'b0, mem_wr = 1'b0;
  logic [15:0] reg_a_q, reg_b_q, reg_c_q, reg_d_q, dr_q;
  logic [3:0]  ar_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] m_gp [4];
  logic [3:0]  m_ar;
  logic [15:0] m_dr;
  logic [15:0] m_mem [16];

  always #10 clk = ~clk;

  rt_bus_datapath u_dut (
    .clk(clk), .rst(rst), .xfer_en(xfer_en), .src_sel(src_sel),
    .dst_sel(dst_sel), .const_word(const_word), .mem_cs(mem_cs),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .reg_a_q(reg_a_q), .reg_b_q(reg_b_q),
    .reg_c_q(reg_c_q), .reg_d_q(reg_d_q), .ar_q(ar_q), .dr_q(dr_q)
  );

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check(tag, "A",  reg_a_q, m_gp[0]);
    check(tag, "B",  reg_b_q, m_gp[1]);
    check(tag, "C",  reg_c_q, m_gp[2]);
    check(tag, "D",  reg_d_q, m_gp[3]);
    check(tag, "AR", {12'b0, ar_q}, {12'b0, m_ar});
    check(tag, "DR", dr_q, m_dr);
  endtask

  // one clock of stimulus: drive at negedge, model at posedge, compare at negedge
  task automatic step(input string tag, input bit x, input logic [2:0] s,
                      input logic [2:0] d, input logic [15:0] k,
                      input bit cs, input bit rd, input bit wr);
    logic [15:0] bus;
    logic [3:0]  old_ar;
    logic [15:0] old_dr;
    xfer_en = x; src_sel = s; dst_sel = d; const_word = k;
    mem_cs = cs; mem_rd = rd; mem_wr = wr;
    case (s)
      3'd4:    bus = m_dr;
      3'd5:    bus = {12'b0, m_ar};
      3'd6:    bus = k;
      3'd7:    bus = 16'h0;
      default: bus = m_gp[s[1:0]];
    endcase
    old_ar = m_ar;
    old_dr = m_dr;
    @(posedge clk);
    if (x) begin
      if (d < 3'd4)       m_gp[d[1:0]] = bus;
      else if (d == 3'd4) m_ar = bus[3:0];
      else if (d == 3'd5) m_dr = bus;
    end
    if (cs && wr && !rd) m_mem[old_ar] = old_dr;
    if (cs && rd)        m_dr = m_mem[old_ar];
    @(negedge clk);
    xfer_en = 1'b0; mem_cs = 1'b0; mem_rd = 1'b0; mem_wr = 1'b0;
    compare_all(tag);
  endtask

  task automatic load_k(input string tag, input logic [2:0] d, input logic [15:0] k);
    step(tag, 1'b1, 3'd6, d, k, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic seed_gp(input logic [15:0] base);
    for (int r = 0; r < 4; r++) load_k("R13", 3'(r), base + 16'(r * 16'h1111));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 4; r++) m_gp[r] = '0;
    m_ar = '0; m_dr = '0;
    for (int i = 0; i < 16; i++) m_mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    compare_all("R1");

    // R13 constant loads into every register, incl. AR and DR
    seed_gp(16'h1234);
    load_k("R13", 3'd4, 16'hFFF9);
    load_k("R13", 3'd5, 16'hBEEF);

    // R2 / R3 every source into every destination
    for (int s = 0; s < 8; s++) begin
      for (int d = 0; d < 8; d++) begin
        seed_gp(16'(16'h0101 * (s + 1) + d));
        load_k("R13", 3'd5, 16'(16'hC000 + s * 16 + d));
        step("R2_R3", 1'b1, 3'(s), 3'(d), 16'(16'h5A00 + s * 8 + d), 1'b0, 1'b0, 1'b0);
      end
    end

    // R4 condition low: nothing moves
    for (int s = 0; s < 8; s++)
      for (int d = 0; d < 8; d++)
        step("R4", 1'b0, 3'(s), 3'(d), 16'hDEAD, 1'b0, 1'b0, 1'b0);

    // R5 not visible before the edge
    xfer_en = 1'b1; src_sel = 3'd6; dst_sel = 3'd0; const_word = 16'h7E57;
    #5;
    check("R5", "A before edge", reg_a_q, m_gp[0]);
    @(posedge clk);
    m_gp[0] = 16'h7E57;
    @(negedge clk);
    xfer_en = 1'b0;
    compare_all("R5");

    // R7 fill memory, R6 read all back
    for (int i = 0; i < 16; i++) begin
      load_k("R7", 3'd4, 16'(i));
      load_k("R7", 3'd5, 16'(16'hA500 ^ (i * 16'h0111)));
      step("R7", 1'b0, 3'd0, 3'd0, 16'h0, 1'b1, 1'b0, 1'b1);
    end
    for (int i = 15; i >= 0; i--) begin
      load_k("R6", 3'd4, 16'(i));
      step("R6", 1'b0, 3'd0, 3'd0, 16'h0, 1'b1, 1'b1, 1'b0);
    end

    // R8 no chip select: write dropped, read dropped
    load_k("R8", 3'd4, 16'd3);
    load_k("R8", 3'd5, 16'h0BAD);
    step("R8", 1'b0, 3'd0, 3'd0, 16'h0, 1'b0, 1'b0, 1'b1);
    step("R8", 1'b0, 3'd0, 3'd0, 16'h0, 1'b0, 1'b1, 1'b0);
    step("R8", 1'b0, 3'd0, 3'd0, 16'h0, 1'b1, 1'b1, 1'b0);

    // R9 read and write together: read wins, word unchanged
    load_k("R9", 3'd4, 16'd7);
    load_k("R9", 3'd5, 16'hF00D);
    step("R9", 1'b0, 3'd0, 3'd0, 16'h0, 1'b1, 1'b1, 1'b1);
    load_k("R9", 3'd5, 16'h1111);
    step("R9", 1'b0, 3'd0, 3'd0, 16'h0, 1'b1, 1'b1, 1'b0);

    // R10 read and bus load of DR in the same cycle
    load_k("R10", 3'd4, 16'd9);
    step("R10", 1'b1, 3'd6, 3'd5, 16'h4242, 1'b1, 1'b1, 1'b0);

    // R11 write while AR is reloaded: old AR and DR are used
    load_k("R11", 3'd4, 16'd2);
    load_k("R11", 3'd5, 16'h2222);
    step("R11", 1'b1, 3'd6, 3'd4, 16'd12, 1'b1, 1'b0, 1'b1);
    step("R11", 1'b1, 3'd6, 3'd5, 16'h9999, 1'b1, 1'b0, 1'b1);
    load_k("R11", 3'd4, 16'd2);
    step("R11", 1'b0, 3'd0, 3'd0, 16'h0, 1'b1, 1'b1, 1'b0);
    load_k("R11", 3'd4, 16'd12);
    step("R11", 1'b0, 3'd0, 3'd0, 16'h0, 1'b1, 1'b1, 1'b0);

    // R12 DR address field into AR
    load_k("R12", 3'd5, 16'hABC5);
    step("R12", 1'b1, 3'd4, 3'd4, 16'h0, 1'b0, 1'b0, 1'b0);
    check("R12", "AR from DR", {12'b0, ar_q}, 16'h0005);

    // R1 reset again after activity
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int r = 0; r < 4; r++) m_gp[r] = '0;
    m_ar = '0; m_dr = '0;
    compare_all("R1");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule